// File: doc/BRIEF.md
# Sixteen-bit two's-complement ALU with status flags

This block is the arithmetic and logic stage of a small 16-bit processor datapath. A 4-bit operation code chooses one of eight functions: add, subtract, compare, bitwise AND, OR and NOT, and arithmetic shifts left and right. Two 16-bit operands and a 4-bit unsigned shift count come from the decoded instruction. The function result appears combinationally on `result`. A write-enable output tells the register file whether to store it.

Four status flags sit in a clocked register: carry, negative, zero and overflow. Only add, subtract and compare load them, and only when `flag_en` is high at the rising clock edge. Compare is a subtract whose difference is thrown away and whose flags are kept. A later branch stage can then test the flags. The logic and shift functions, and any operation code outside the eight, leave the flags as they were.

Top module: `alu16_core`

## Requirements
- R1: Opcode 4'b0101 drives `result` with `src_a + src_b` modulo 2^16, and `wr_en` is high.
- R2: Opcode 4'b0110 drives `result` with `src_a - src_b` modulo 2^16, and `wr_en` is high.
- R3: Opcodes 4'b0111, 4'b1000 and 4'b1001 drive `result` with bitwise AND, bitwise OR, and the bitwise complement of `src_a`. For NOT, `src_b` has no effect.
- R4: Opcode 4'b1010 drives `result` with `src_a` shifted left by `shamt` (0 to 15), with zeros filling the low bits.
- R5: Opcode 4'b1011 drives `result` with `src_a` shifted right by `shamt` (0 to 15), with copies of bit 15 filling the high bits.
- R6: Opcode 4'b1100 (compare) holds `wr_en` low and loads the flags exactly as a subtract of `src_b` from `src_a` would.
- R7: After an add, subtract or compare is captured, `flag_n` equals bit 15 of the difference or sum, and `flag_z` is high exactly when that value is all zeros.
- R8: `flag_c` is loaded with the carry out of bit 15 of `src_a + src_b` for an add, and of `src_a + ~src_b + 1` for a subtract or compare.
- R9: `flag_v` is loaded high for an add when both operands share a sign and the sum's sign differs from it. For a subtract or compare, it is loaded high when the operand signs differ and the difference's sign differs from `src_a`.
- R10: The flags keep their value across any edge where `flag_en` is low, or where the opcode is not add, subtract or compare.
- R11: `wr_en` is high for opcodes 4'b0101 through 4'b1011 and low for every other opcode. For opcodes outside 4'b0101 to 4'b1100, `result` is zero.
- R12: A synchronous active-high `rst` clears all four flags at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op | input | 4 | Operation code |
| src_a | input | 16 | First operand (minuend, shift source, NOT source) |
| src_b | input | 16 | Second operand (addend, subtrahend, logic mask) |
| shamt | input | 4 | Unsigned shift count |
| flag_en | input | 1 | Strobe that allows arithmetic ops to load the flags |
| result | output | 16 | Combinational function result |
| wr_en | output | 1 | Result should be written to a destination register |
| flag_c | output | 1 | Registered carry flag |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_v | output | 1 | Registered overflow flag |

## Verification
Flags that survive is the hardest case to see at the ports. A flag value loaded by one operation has to stay put while a run of logic and shift operations, unused opcodes, and an edge with `flag_en` low go past. A stale or wrongly updated flag looks the same as a fresh one unless its value is known to differ from what the intervening operation would produce.

The vector table therefore orders its rows deliberately. A signed-overflow subtract first leaves carry and overflow set. Then logic and shift rows follow, whose own results would clear those flags if they leaked through. Later, two compares that load opposite flag patterns each precede an unused opcode and a strobe-low add of zeros.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 4'b0101,
        OP_SUB = 4'b0110,
        OP_AND = 4'b0111,
        OP_OR  = 4'b1000,
        OP_NOT = 4'b1001,
        OP_SHL = 4'b1010,
        OP_SHR = 4'b1011,
        OP_CMP = 4'b1100
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic n;
        logic z;
        logic v;
    } alu_flags_t;

    localparam alu_flags_t FLAGS_CLEAR = '{c: 1'b0, n: 1'b0, z: 1'b0, v: 1'b0};

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_ARITH = 2'd1,
        SRC_BITS  = 2'd2
    } res_src_e;

    function automatic logic is_arith(input logic [OPW-1:0] code);
        return (code == OP_ADD) || (code == OP_SUB) || (code == OP_CMP);
    endfunction

    function automatic logic is_bitop(input logic [OPW-1:0] code);
        return (code >= OP_AND) && (code <= OP_SHR);
    endfunction

    function automatic logic writes_dest(input logic [OPW-1:0] code);
        return (code >= OP_ADD) && (code <= OP_SHR);
    endfunction

    function automatic res_src_e pick_source(input logic [OPW-1:0] code);
        if (is_arith(code))      return SRC_ARITH;
        else if (is_bitop(code)) return SRC_BITS;
        else                     return SRC_NONE;
    endfunction

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output alu_flags_t   fl
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = wide[W-1:0];
        fl.c  = wide[W];
        fl.n  = wide[MSB];
        fl.z  = (wide[W-1:0] == '0);
        fl.v  = (a[MSB] == b_eff[MSB]) && (wide[MSB] != a[MSB]);
    end

    // R9
    always_comb begin
        add_ovf_sign_chk: assert (sub || !fl.v || (a[MSB] == b[MSB]));
    end

    // R9
    always_comb begin
        sub_ovf_sign_chk: assert (!sub || !fl.v || (a[MSB] != b[MSB]));
    end

endmodule

// File: rtl/alu16_bitops.sv
module alu16_bitops
    import alu16_pkg::*;
#(
    parameter int W  = 16,
    parameter int SW = 4
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [SW-1:0]  sh,
    output logic [W-1:0]   res
);
    localparam int MSB = W - 1;

    logic [W-1:0] shl_v;
    logic [W-1:0] shr_v;

    always_comb begin
        shl_v = a << sh;
        shr_v = W'($signed(a) >>> sh);
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_NOT:  res = ~a;
            OP_SHL:  res = shl_v;
            OP_SHR:  res = shr_v;
            default: res = '0;
        endcase
    end

    // R5
    always_comb begin
        shr_sign_keep_chk: assert (op != OP_SHR || res[MSB] == a[MSB]);
    end

    // R4
    always_comb begin
        shl_low_zero_chk: assert (op != OP_SHL || sh == '0 || res[0] == 1'b0);
    end

endmodule

// File: rtl/alu16_flagreg.sv
module alu16_flagreg
    import alu16_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       upd,
    input  alu_flags_t nxt,
    output alu_flags_t q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= FLAGS_CLEAR;
        else if (upd) q <= nxt;
    end

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(q));

    // R7
    flag_load_chk: assert property (@(posedge clk) disable iff (rst)
        upd |=> (q == $past(nxt)));

endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W  = 16,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    op,
    input  logic [W-1:0]  src_a,
    input  logic [W-1:0]  src_b,
    input  logic [SW-1:0] shamt,
    input  logic          flag_en,
    output logic [W-1:0]  result,
    output logic          wr_en,
    output logic          flag_c,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_v
);
    logic [W-1:0] arith_res;
    logic [W-1:0] bits_res;
    alu_flags_t   arith_fl;
    alu_flags_t   flags_q;
    logic         do_sub;
    logic         flag_upd;
    res_src_e     src_sel;

    assign do_sub   = (op == OP_SUB) || (op == OP_CMP);
    assign flag_upd = flag_en && is_arith(op);
    assign src_sel  = pick_source(op);

    alu16_addsub #(.W(W)) u_addsub (
        .a   (src_a),
        .b   (src_b),
        .sub (do_sub),
        .sum (arith_res),
        .fl  (arith_fl)
    );

    alu16_bitops #(.W(W), .SW(SW)) u_bits (
        .op  (op),
        .a   (src_a),
        .b   (src_b),
        .sh  (shamt),
        .res (bits_res)
    );

    alu16_flagreg u_flags (
        .clk (clk),
        .rst (rst),
        .upd (flag_upd),
        .nxt (arith_fl),
        .q   (flags_q)
    );

    always_comb begin
        case (src_sel)
            SRC_ARITH: result = arith_res;
            SRC_BITS:  result = bits_res;
            default:   result = '0;
        endcase
        wr_en = writes_dest(op);
    end

    assign flag_c = flags_q.c;
    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_v = flags_q.v;

    // R6
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CMP) |-> !wr_en);

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_en && is_arith(op)) |=> (flag_z == ($past(result) == '0)));

    // R10
    logic_keeps_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (!flag_en || !is_arith(op)) |=> ($stable(flag_c) && $stable(flag_v)));

endmodule

// File: tb/alu16_core_test.sv
module alu16_core_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op;
    logic [15:0] src_a, src_b;
    logic [3:0]  shamt;
    logic        flag_en;
    logic [15:0] result;
    logic        wr_en, flag_c, flag_n, flag_z, flag_v;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    alu16_core uut (
        .clk(clk), .rst(rst), .op(op), .src_a(src_a), .src_b(src_b),
        .shamt(shamt), .flag_en(flag_en), .result(result), .wr_en(wr_en),
        .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v)
    );

    // {op, a, b, shamt, expected result, expected wr_en, expected flags {c,n,z,v} after edge}
    localparam int NV = 16;
    localparam logic [60:0] VEC [NV] = '{
        {4'h5, 16'h0003, 16'h0004, 4'h0, 16'h0007, 1'b1, 4'b0000}, // R1 R7
        {4'h5, 16'h7FFF, 16'h0001, 4'h0, 16'h8000, 1'b1, 4'b0101}, // R1 R9
        {4'h5, 16'hFFFF, 16'h0001, 4'h0, 16'h0000, 1'b1, 4'b1010}, // R1 R8
        {4'h6, 16'h0005, 16'h0007, 4'h0, 16'hFFFE, 1'b1, 4'b0100}, // R2 R8
        {4'h6, 16'h8000, 16'h0001, 4'h0, 16'h7FFF, 1'b1, 4'b1001}, // R2 R9
        {4'h7, 16'h00F0, 16'h0FF0, 4'h0, 16'h00F0, 1'b1, 4'b1001}, // R3 R10
        {4'h8, 16'h00F0, 16'h0F0F, 4'h0, 16'h0FFF, 1'b1, 4'b1001}, // R3 R10
        {4'h9, 16'h0000, 16'h1234, 4'h0, 16'hFFFF, 1'b1, 4'b1001}, // R3 R10
        {4'hA, 16'h0004, 16'h0000, 4'h1, 16'h0008, 1'b1, 4'b1001}, // R4
        {4'hA, 16'h0001, 16'h0000, 4'hF, 16'h8000, 1'b1, 4'b1001}, // R4
        {4'hA, 16'h00FF, 16'h0000, 4'h0, 16'h00FF, 1'b1, 4'b1001}, // R4
        {4'hB, 16'h8000, 16'h0000, 4'h3, 16'hF000, 1'b1, 4'b1001}, // R5
        {4'hB, 16'h4000, 16'h0000, 4'hF, 16'h0000, 1'b1, 4'b1001}, // R5
        {4'hC, 16'h0009, 16'h0009, 4'h0, 16'h0000, 1'b0, 4'b1010}, // R6
        {4'hC, 16'h0003, 16'h0009, 4'h0, 16'hFFFA, 1'b0, 4'b0100}, // R6
        {4'h0, 16'h0001, 16'h0001, 4'h0, 16'h0000, 1'b0, 4'b0100}  // R11
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string res_req(input logic [3:0] code);
        case (code)
            4'h5:                   return "R1 add";
            4'h6:                   return "R2 sub";
            4'h7, 4'h8, 4'h9:       return "R3 logic";
            4'hA:                   return "R4 shl";
            4'hB:                   return "R5 shr";
            4'hC:                   return "R6 compare";
            default:                return "R11 unused";
        endcase
    endfunction

    task automatic apply(input logic [3:0] o, input logic [15:0] a, input logic [15:0] b,
                         input logic [3:0] s, input logic en);
        @(negedge clk);
        op = o; src_a = a; src_b = b; shamt = s; flag_en = en;
        #1;
    endtask

    function automatic logic [15:0] flags16();
        return {12'h0, flag_c, flag_n, flag_z, flag_v};
    endfunction

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; op = 4'h0; src_a = '0; src_b = '0; shamt = '0; flag_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R12: flags cleared by reset
        check("R12 reset flags", flags16(), 16'h0000);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [60:0] v;
            v = VEC[i];
            apply(v[60:57], v[56:41], v[40:25], v[24:21], 1'b1);
            check(res_req(v[60:57]), result, v[20:5]);
            check("R11 R6 wr_en", {15'h0, wr_en}, {15'h0, v[4]});
            @(posedge clk);
            #1;
            check("R7 R8 R9 R10 flags", flags16(), {12'h0, v[3:0]});
        end

        // R10: strobe low, add of zeros would set Z and clear N
        apply(4'h5, 16'h0000, 16'h0000, 4'h0, 1'b0);
        check("R1 add zeros", result, 16'h0000);
        @(posedge clk); #1;
        check("R10 strobe low keeps flags", flags16(), 16'h0004);

        // R3: NOT ignores src_b
        apply(4'h9, 16'h5A5A, 16'hFFFF, 4'h0, 1'b1);
        check("R3 not ignores b", result, 16'hA5A5);

        // R6: compare with strobe loads C,Z; a follow-up unused opcode keeps them
        apply(4'hC, 16'h7FFF, 16'h7FFF, 4'h0, 1'b1);
        check("R6 compare wr_en", {15'h0, wr_en}, 16'h0000);
        @(posedge clk); #1;
        check("R6 compare flags", flags16(), 16'h000A);
        apply(4'hF, 16'hFFFF, 16'h0001, 4'h0, 1'b1);
        check("R11 unused result", result, 16'h0000);
        @(posedge clk); #1;
        check("R10 unused keeps flags", flags16(), 16'h000A);

        // R12: reset mid-run clears flags
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        check("R12 reset mid-run", flags16(), 16'h0000);
        @(negedge clk);
        rst = 1'b0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule